// File: doc/BRIEF.md
# SMI Command/Status Port Controller

This block sits on a simple I/O slave bus and provides two byte-wide ports for power-management traffic. Any write to the command port latches the byte and raises a System Management Interrupt. The pulse goes either to the boot processor alone or to every processor in the system. The choice depends on the feature set that firmware has negotiated through the status port.

The status port runs a two-mode handshake. A write with bit 1 set is a query. The following readback reports whether the negotiation interface exists and which host features are on offer. A write with bit 1 clear is a set request for the features named in bits 7:2. The following readback reports whether the request was accepted. Bit 0 is plain storage in both modes. Firmware that never negotiates only writes 0x00 or 0x01 and sees legacy single-target behaviour.

Top module: `smi_port_ctrl`

## Requirements
- R1: After reset (rst_ni low), the command port reads 0x00, the status port reads 0x00, smi_o is all zero, and delivery is unicast.
- R2: A write to CMD_ADDR (default 0x00B2) latches wdata_i. The command port reads back that byte until the next command write. Writes to other addresses leave it unchanged.
- R3: Every command-port write drives a nonzero smi_o for exactly one cycle, the cycle after the write edge. No other access produces a pulse.
- R4: In unicast mode, a command write pulses only smi_o[0].
- R5: Status bit 0 reads back the bit 0 of the last status write, in either mode.
- R6: A status write with bit 1 = 1 (query) leaves the active feature set unchanged and ignores written bits 7:2. Afterwards bit 1 reads 0 when IFACE_EN = 1 (1 otherwise), and bits 7:2 read HOST_FEATURES (0x05 by default, so the port shows 0x14 plus bit 0).
- R7: A status write with bit 1 = 0 whose request in bits 7:2 lies inside HOST_FEATURES makes that request the active set. Afterwards bits 7:1 read as zero.
- R8: A set request with any bit outside HOST_FEATURES is rejected. Bit 1 reads 1, bits 7:2 read 0, and the active set stays unchanged (for example, 0x08 with default parameters).
- R9: A status write of 0x00 or 0x01 clears all active features and always succeeds. Bits 7:1 then read 0, and delivery returns to unicast.
- R10: When the active set contains the broadcast feature (status bit 2), a command write pulses all N_CPU bits of smi_o together.
- R11: Reads have no side effects. A read of an address other than the two ports returns 0x00, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | I/O address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_i is high |
| smi_o | output | N_CPU | Per-processor SMI pulses |

## Verification
Most internal faults in this block become visible at one of two places. If the active feature set is wrong, the fault shows only on the next command write, as a pulse vector that is one-hot where it should be all-ones or the reverse. The stimulus therefore follows every negotiation step with a command write. If the status readback state is wrong, the fault shows on the very next status read, so each write is followed by readbacks of both ports in the same cycle. Rejected requests and query writes are each followed by a command write, which shows that the previous delivery mode survived them.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FEAT_W = 6;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CMD  = 2'd1,
    ACC_STS  = 2'd2
  } acc_e;
endpackage

// File: rtl/smi_addr_dec.sv
module smi_addr_dec
  import smi_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2,
  parameter logic [ADDR_W-1:0] STS_ADDR = 16'h00B3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output acc_e              sel_o,
  output logic              wr_cmd_o,
  output logic              wr_sts_o
);
  always_comb begin
    if (addr_i == CMD_ADDR)      sel_o = ACC_CMD;
    else if (addr_i == STS_ADDR) sel_o = ACC_STS;
    else                         sel_o = ACC_NONE;
  end

  assign wr_cmd_o = wr_i && (sel_o == ACC_CMD);
  assign wr_sts_o = wr_i && (sel_o == ACC_STS);
endmodule

// File: rtl/smi_sts_neg.sv
module smi_sts_neg
  import smi_pkg::*;
#(
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 6'b000101,
  parameter bit                IFACE_EN      = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] sts_o,
  output logic [FEAT_W-1:0] active_o
);
  logic              keep_q;
  logic              flag_q;
  logic [FEAT_W-1:0] field_q;
  logic [FEAT_W-1:0] active_q;

  logic [FEAT_W-1:0] req;
  logic              is_query;
  logic              req_ok;

  assign req      = wdata_i[DATA_W-1:2];
  assign is_query = wdata_i[1];
  // empty request is the legacy clear and is always accepted
  assign req_ok   = (req == '0) || (IFACE_EN && ((req & ~HOST_FEATURES) == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q   <= 1'b0;
      flag_q   <= 1'b0;
      field_q  <= '0;
      active_q <= '0;
    end else if (wr_i) begin
      keep_q <= wdata_i[0];
      if (is_query) begin
        flag_q  <= !IFACE_EN;
        field_q <= IFACE_EN ? HOST_FEATURES : '0;
      end else begin
        flag_q  <= !req_ok;
        field_q <= '0;
        if (req_ok) active_q <= req;
      end
    end
  end

  assign sts_o    = {field_q, flag_q, keep_q};
  assign active_o = active_q;
endmodule

// File: rtl/smi_fanout.sv
module smi_fanout #(
  parameter int unsigned N_CPU = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             bcast_i,
  output logic [N_CPU-1:0] smi_o
);
  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    logic hit;
    if (g == 0) begin : g_boot
      assign hit = fire_i;
    end else begin : g_ap
      assign hit = fire_i && bcast_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) smi_o[g] <= 1'b0;
      else         smi_o[g] <= hit;
    end
  end
endmodule

// File: rtl/smi_port_ctrl.sv
module smi_port_ctrl
  import smi_pkg::*;
#(
  parameter int unsigned       N_CPU         = 4,
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR      = 16'h00B2,
  parameter logic [ADDR_W-1:0] STS_ADDR      = 16'h00B3,
  parameter logic [5:0]        HOST_FEATURES = 6'b000101,
  parameter bit                IFACE_EN      = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_CPU-1:0]  smi_o
);
  localparam int unsigned BCAST_BIT = 0;  // field bit 0 = status bit 2

  acc_e              sel;
  logic              wr_cmd;
  logic              wr_sts;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] sts_view;
  logic [FEAT_W-1:0] active;

  smi_addr_dec #(
    .ADDR_W  (ADDR_W),
    .CMD_ADDR(CMD_ADDR),
    .STS_ADDR(STS_ADDR)
  ) u_dec (
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .sel_o   (sel),
    .wr_cmd_o(wr_cmd),
    .wr_sts_o(wr_sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (wr_cmd) cmd_q <= wdata_i;
  end

  smi_sts_neg #(
    .HOST_FEATURES(HOST_FEATURES),
    .IFACE_EN     (IFACE_EN)
  ) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sts),
    .wdata_i (wdata_i),
    .sts_o   (sts_view),
    .active_o(active)
  );

  smi_fanout #(
    .N_CPU(N_CPU)
  ) u_fan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wr_cmd),
    .bcast_i(active[BCAST_BIT]),
    .smi_o  (smi_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        ACC_CMD: rdata_o = cmd_q;
        ACC_STS: rdata_o = sts_view;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/smi_port_chk.sv
module smi_port_chk #(
  parameter int unsigned       N_CPU    = 4,
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2,
  parameter logic [ADDR_W-1:0] STS_ADDR = 16'h00B3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic [N_CPU-1:0]  smi_o,
  input logic [7:0]        cmd_q,
  input logic [7:0]        sts_view,
  input logic [5:0]        active
);
  logic cmd_wr;
  logic sts_wr;
  assign cmd_wr = wr_i && (addr_i == CMD_ADDR);
  assign sts_wr = wr_i && (addr_i == STS_ADDR);

  // R3
  pulse_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> (smi_o != '0));

  // R3
  no_stray_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> (smi_o == '0));

  // R4
  boot_always_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o != '0) |-> smi_o[0]);

  // R10
  one_or_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o != '0) |-> ($countones(smi_o) == 1 || smi_o == '1));

  // R2
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> $stable(cmd_q));

  // R6
  query_keeps_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && wdata_i[1]) |=> $stable(active));

  // R9
  legacy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && wdata_i[7:1] == 7'd0) |=> (sts_view[7:1] == 7'd0 && active == 6'd0));
endmodule

bind smi_port_ctrl smi_port_chk #(
  .N_CPU   (N_CPU),
  .ADDR_W  (ADDR_W),
  .CMD_ADDR(CMD_ADDR),
  .STS_ADDR(STS_ADDR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .smi_o   (smi_o),
  .cmd_q   (cmd_q),
  .sts_view(sts_view),
  .active  (active)
);

// File: tb/smi_port_ctrl_bench.sv
module smi_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CPU      = 4;
  localparam logic [15:0] A_CMD = 16'h00B2;
  localparam logic [15:0] A_STS = 16'h00B3;
  localparam logic [15:0] A_OTH = 16'h00B4;

  typedef struct packed {
    logic [1:0] kind;   // 0 cmd, 1 status, 2 other address
    logic [7:0] wd;
    logic [7:0] sts;
    logic [7:0] cmd;
    logic [3:0] smi;
  } vec_t;

  localparam int NV = 21;
  // defaults: host mask 0x05 -> port bits 2 and 4 (0x14)
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h11, 8'h00, 8'h11, 4'b0001},  // R2 R3 R4 unicast from reset
    '{2'd1, 8'h01, 8'h01, 8'h11, 4'b0000},  // R5 R9
    '{2'd1, 8'h02, 8'h14, 8'h11, 4'b0000},  // R6 query
    '{2'd1, 8'hFF, 8'h15, 8'h11, 4'b0000},  // R6 field ignored, R5
    '{2'd0, 8'h22, 8'h15, 8'h22, 4'b0001},  // R6 query keeps unicast
    '{2'd1, 8'h04, 8'h00, 8'h22, 4'b0000},  // R7 request broadcast
    '{2'd0, 8'h33, 8'h00, 8'h33, 4'b1111},  // R10
    '{2'd1, 8'h09, 8'h03, 8'h33, 4'b0000},  // R8 bit3 outside mask
    '{2'd0, 8'h44, 8'h03, 8'h44, 4'b1111},  // R8 set unchanged
    '{2'd1, 8'h15, 8'h01, 8'h44, 4'b0000},  // R7 full subset
    '{2'd0, 8'h55, 8'h01, 8'h55, 4'b1111},  // R10
    '{2'd1, 8'h10, 8'h00, 8'h55, 4'b0000},  // R7 bit4 only
    '{2'd0, 8'h66, 8'h00, 8'h66, 4'b0001},  // R4
    '{2'd1, 8'h04, 8'h00, 8'h66, 4'b0000},  // R7
    '{2'd1, 8'h00, 8'h00, 8'h66, 4'b0000},  // R9 clear
    '{2'd0, 8'h77, 8'h00, 8'h77, 4'b0001},  // R9 unicast again
    '{2'd2, 8'hFF, 8'h00, 8'h77, 4'b0000},  // R11 other address
    '{2'd1, 8'h05, 8'h01, 8'h77, 4'b0000},  // R7 R5
    '{2'd0, 8'h88, 8'h01, 8'h88, 4'b1111},  // R10
    '{2'd1, 8'h01, 8'h01, 8'h88, 4'b0000},  // R9 clear with bit0
    '{2'd0, 8'h99, 8'h01, 8'h99, 4'b0001}   // R9 R4
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      addr = '0;
  logic             rd = 1'b0;
  logic             wr = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic [N_CPU-1:0] smi;

  int applied = 0;
  int miscomp = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_port_ctrl #(.N_CPU(N_CPU)) u_smi_port_ctrl (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .rd_i   (rd),
    .wr_i   (wr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .smi_o  (smi)
  );

  task automatic check(input bit ok, input string what, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s act=0x%02h exp=0x%02h", what, act, exp);
    end
  endtask

  // write on one edge; returns at the following negedge with the pulse visible
  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1;
    d = rdata;
    rd = 1'b0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      miscomp++;
      $display("FAIL watchdog act=%0d exp=<5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    check(smi == '0, "R1 smi in reset", {4'h0, smi}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(A_CMD, v);
    check(v == 8'h00, "R1 cmd after reset", v, 8'h00);
    do_read(A_STS, v);
    check(v == 8'h00, "R1 status after reset", v, 8'h00);
    check(smi == '0, "R1 smi idle", {4'h0, smi}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      a = (VEC[i].kind == 2'd0) ? A_CMD : (VEC[i].kind == 2'd1) ? A_STS : A_OTH;
      do_write(a, VEC[i].wd);
      check(smi == VEC[i].smi, $sformatf("R3 R4 R10 pulse vec %0d", i), {4'h0, smi}, {4'h0, VEC[i].smi});
      do_read(A_STS, v);
      check(v == VEC[i].sts, $sformatf("R5 R6 R7 R8 R9 status vec %0d", i), v, VEC[i].sts);
      do_read(A_CMD, v);
      check(v == VEC[i].cmd, $sformatf("R2 cmd vec %0d", i), v, VEC[i].cmd);
      @(negedge clk);
      check(smi == '0, $sformatf("R3 single cycle vec %0d", i), {4'h0, smi}, 8'h00);
    end

    // R11 unmapped read returns zero, reads leave state alone
    do_read(A_OTH, v);
    check(v == 8'h00, "R11 unmapped read", v, 8'h00);
    do_read(A_STS, v);
    do_read(A_STS, v2);
    check(v2 == v, "R11 repeated status read", v2, v);
    check(smi == '0, "R11 read makes no pulse", {4'h0, smi}, 8'h00);

    // R3 back-to-back command writes give two pulses
    @(negedge clk);
    addr = A_CMD; wdata = 8'hA1; wr = 1'b1;
    @(negedge clk);
    check(smi == 4'b0001, "R3 first of pair", {4'h0, smi}, 8'h01);
    wdata = 8'hA2;
    @(negedge clk);
    wr = 1'b0;
    check(smi == 4'b0001, "R3 second of pair", {4'h0, smi}, 8'h01);
    do_read(A_CMD, v);
    check(v == 8'hA2, "R2 last command kept", v, 8'hA2);

    // R1 reset during broadcast restores unicast
    do_write(A_STS, 8'h04);
    do_write(A_CMD, 8'hB0);
    check(smi == 4'b1111, "R10 before reset", {4'h0, smi}, 8'h0F);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(smi == '0, "R1 async clear", {4'h0, smi}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    do_write(A_CMD, 8'hB1);
    check(smi == 4'b0001, "R1 unicast after reset", {4'h0, smi}, 8'h01);

    // R8 invalid request while nothing active keeps unicast
    do_write(A_STS, 8'h24);
    do_read(A_STS, v);
    check(v == 8'h02, "R8 reject flag", v, 8'h02);
    do_write(A_CMD, 8'hB2);
    check(smi == 4'b0001, "R8 rejected broadcast", {4'h0, smi}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule